// File: doc/BRIEF.md
# Stride-Detecting Stream Prefetcher

This block sits next to a core's load path and watches the addresses of its demand accesses. For each non-repeating access it proposes one line for a cache to fetch early. When the gap between accesses has been the same twice in a row, it treats the accesses as a stream with that stride and aims four strides past the current address. Until then it asks for the line that follows the accessed one, so each fetched line behaves like half of a double-width line.

Each proposal is line-aligned. A proposal is dropped in three cases: it would land in a different 4 KB page from the access that caused it, it repeats the line of the previous proposal, or the access repeats the previous address. The output is a single valid/ready slot. A newer proposal overwrites one that has not yet been accepted, so a stall loses the stale request and never builds a queue.

Top module: `stride_prefetcher`

## Requirements
- R1: While reset is held, and on the first cycle after it, `pf_valid` is low.
- R2: Every address presented with `pf_valid` high has its low six bits at zero, so it is aligned to a 64-byte line.
- R3: If an access does not confirm a stride, the proposal is the accessed line's base address plus 64. This includes the first access after reset.
- R4: The delta is the access address minus the previous stored address, taken modulo 2^ADDR_W. An access confirms a stride when its delta is non-zero and equals the previous stored delta. Any other non-zero delta is stored as the new candidate stride and leaves the stride unconfirmed.
- R5: If an access confirms a stride, the proposal is the line containing (access address + 4 × delta).
- R6: A proposal whose address bits [ADDR_W-1:12] differ from those of the triggering access is not issued.
- R7: An access to the same address as the previous stored access makes no proposal and leaves the stored address and candidate stride unchanged.
- R8: While `pf_ready` is low, a pending request stays valid with a stable address. A newly generated proposal replaces it.
- R9: A proposal whose line equals the line of the most recently issued proposal is dropped.
- R10: Negative strides are confirmed and projected with two's-complement arithmetic, and the page rule of R6 still applies to them.
- R11: A proposal appears on the outputs one cycle after its access edge. When the request is accepted (`pf_valid` and `pf_ready` high) and no new proposal arrives in that cycle, `pf_valid` falls on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | A demand access is presented this cycle |
| acc_addr | input | ADDR_W | Byte address of the demand access |
| pf_valid | output | 1 | A prefetch request is pending |
| pf_ready | input | 1 | The cache accepts the pending request |
| pf_addr | output | ADDR_W | Line-aligned prefetch address |

## Verification
Some properties hold on every cycle, and the assertions check those: alignment, the idle state after reset, a request holding steady during a stall, the valid flag falling after an accepted handshake, and a newly loaded request never leaving the triggering page. Other behaviour depends on access history, and only the bench's address sweeps can show it. This covers when a stride becomes confirmed, the switch between next-line and four-strides-ahead targets, duplicate suppression, the effect of a repeated address, and the replacement of a stalled request. The sweeps cover positive, negative, small and large strides from start points near page edges.

// File: rtl/stride_prefetcher.sv
module stride_prefetcher #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BITS  = 6,
  parameter int PAGE_BITS  = 12,
  parameter int AHEAD_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr
);
  localparam int TAG_W = ADDR_W - LINE_BITS;
  localparam logic [ADDR_W-1:0] LINE_BYTES = ADDR_W'(1) << LINE_BITS;

  logic              seen_q;
  logic [ADDR_W-1:0] prev_addr_q;
  logic [ADDR_W-1:0] cand_q;
  logic              out_v_q;
  logic [TAG_W-1:0]  out_line_q;
  logic              hist_v_q;
  logic [TAG_W-1:0]  hist_line_q;

  logic [ADDR_W-1:0] delta, far_tgt, near_tgt, tgt;
  logic              repeat_acc, locked, same_page, dup, fire;

  assign delta      = acc_addr - prev_addr_q;
  assign repeat_acc = seen_q && (delta == '0);
  assign locked     = seen_q && (delta != '0) && (delta == cand_q);
  assign far_tgt    = acc_addr + (delta << AHEAD_LOG2);
  assign near_tgt   = {acc_addr[ADDR_W-1:LINE_BITS], {LINE_BITS{1'b0}}} + LINE_BYTES;
  assign tgt        = locked ? far_tgt : near_tgt;
  assign same_page  = tgt[ADDR_W-1:PAGE_BITS] == acc_addr[ADDR_W-1:PAGE_BITS];
  assign dup        = hist_v_q && (tgt[ADDR_W-1:LINE_BITS] == hist_line_q);
  assign fire       = acc_valid && !repeat_acc && same_page && !dup;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q      <= 1'b0;
      prev_addr_q <= '0;
      cand_q      <= '0;
      out_v_q     <= 1'b0;
      out_line_q  <= '0;
      hist_v_q    <= 1'b0;
      hist_line_q <= '0;
    end else begin
      if (acc_valid && !repeat_acc) begin
        seen_q      <= 1'b1;
        prev_addr_q <= acc_addr;
        if (seen_q) cand_q <= delta;
      end
      if (fire) begin
        out_v_q     <= 1'b1;
        out_line_q  <= tgt[ADDR_W-1:LINE_BITS];
        hist_v_q    <= 1'b1;
        hist_line_q <= tgt[ADDR_W-1:LINE_BITS];
      end else if (pf_ready) begin
        out_v_q <= 1'b0;
      end
    end
  end

  assign pf_valid = out_v_q;
  assign pf_addr  = {out_line_q, {LINE_BITS{1'b0}}};
endmodule

// File: rtl/stride_prefetcher_chk.sv
module stride_prefetcher_chk #(
  parameter int ADDR_W    = 32,
  parameter int LINE_BITS = 6,
  parameter int PAGE_BITS = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              pf_valid,
  input logic              pf_ready,
  input logic [ADDR_W-1:0] pf_addr
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !pf_valid);

  // R2
  line_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> pf_addr[LINE_BITS-1:0] == '0);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && !pf_ready && !acc_valid |=> pf_valid && $stable(pf_addr));

  // R11
  accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && pf_ready && !acc_valid |=> !pf_valid);

  // R6
  page_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && (pf_ready || !pf_valid) |=>
      !pf_valid || pf_addr[ADDR_W-1:PAGE_BITS] == $past(acc_addr[ADDR_W-1:PAGE_BITS]));
endmodule

bind stride_prefetcher stride_prefetcher_chk #(
  .ADDR_W(ADDR_W), .LINE_BITS(LINE_BITS), .PAGE_BITS(PAGE_BITS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
  .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr)
);

// File: tb/stride_prefetcher_tb_top.sv
module stride_prefetcher_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        pf_valid;
  logic        pf_ready = 1'b1;
  logic [31:0] pf_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  stride_prefetcher dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr)
  );

  bit          m_seen, m_hv, m_pv;
  logic [31:0] m_prev, m_cand, m_hline, m_pa;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(bit v, logic [31:0] a);
    string tag;
    logic [31:0] d, t;
    bit rep, lk, fire;
    tag = "R11";
    fire = 1'b0;
    if (v) begin
      d   = a - m_prev;
      rep = m_seen && d == 0;
      lk  = m_seen && d != 0 && d == m_cand;
      t   = lk ? (a + d * 4) & ~32'h3F : (a & ~32'h3F) + 32'h40;
      if (rep) tag = "R7";
      else if ((t >> 12) != (a >> 12)) tag = "R6";
      else if (m_hv && t == m_hline) tag = "R9";
      else begin
        fire = 1'b1;
        tag = lk ? (d[31] ? "R10" : "R4/R5") : "R3";
      end
      if (!rep) begin
        if (m_seen) m_cand = d;
        m_seen = 1'b1;
        m_prev = a;
      end
      if (fire) begin m_hv = 1'b1; m_hline = t; end
    end
    if (fire) begin m_pv = 1'b1; m_pa = t; end
    else if (pf_ready) m_pv = 1'b0;
    @(negedge clk);
    acc_valid = v;
    acc_addr  = a;
    @(negedge clk);
    acc_valid = 1'b0;
    check(pf_valid == m_pv, tag, {31'b0, pf_valid}, {31'b0, m_pv});
    if (m_pv) begin
      check(pf_addr == m_pa, tag, pf_addr, m_pa);
      check(pf_addr[5:0] == 0, "R2", pf_addr, m_pa);
    end
  endtask

  task automatic idle();
    if (pf_ready) m_pv = 1'b0;
    @(negedge clk);
    acc_valid = 1'b0;
    @(negedge clk);
    check(pf_valid == m_pv, "R11", {31'b0, pf_valid}, {31'b0, m_pv});
  endtask

  initial begin
    int strides [6] = '{1, 64, 'h200, -64, -1, 24};
    int starts  [3] = '{'h1000, 'h5F80, 'h20FF0};
    m_seen = 0; m_hv = 0; m_pv = 0; m_prev = 0; m_cand = 0; m_hline = 0; m_pa = 0;
    repeat (3) @(negedge clk);
    check(pf_valid == 1'b0, "R1", {31'b0, pf_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pf_valid == 1'b0, "R1", {31'b0, pf_valid}, 32'h0);

    for (int s = 0; s < 6; s++)
      for (int b = 0; b < 3; b++) begin
        for (int i = 0; i < 12; i++) begin
          step(1'b1, 32'(starts[b] + i * strides[s]));
          if (i == 5) step(1'b1, 32'(starts[b] + i * strides[s]));
        end
        idle();
      end

    // R9 duplicate next-line proposals
    step(1'b1, 32'h8000);
    step(1'b1, 32'h8008);
    step(1'b1, 32'h8010);

    // R8 stall: hold, then replace
    pf_ready = 1'b0;
    step(1'b1, 32'h9000);
    idle();
    idle();
    step(1'b1, 32'h9100);
    idle();
    pf_ready = 1'b1;
    idle();
    idle();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule